// File: doc/BRIEF.md
# Strobed Parallel Port Handshake Controller

This block runs the strobe handshake for an eight-bit bidirectional port (port C) and an eight-bit output port (port B). An incoming strobe line tells the block when to capture the port C pins or when the far end has accepted data. An outgoing strobe line tells the far end that a port B write happened, that the block is ready for data, or that data is waiting. Software reaches it through a small synchronous register bus: a control register that selects mode, strobe edge, strobe polarity, pulse or level signalling and the three-state variant; a capture/output latch; a port C output latch; a per-bit direction register; and the port B register.

The control register also holds a strobe-event flag. An interrupt is raised from the flag and its enable bit. The flag is cleared only by a two-step sequence: first a read of the control register while the flag is set, then an access to the capture latch. That access is a read in the input modes and a write in output handshake mode. This lets a driver acknowledge the event as part of its normal data transfer.

Top module: `strobe_port_ctrl`

## Requirements
- R1: After reset, the control and direction registers read 0, no port C pad is driven (`pc_oe` = 0), the interrupt is low and `strb_o` is low.
- R2: Register offsets are: 0 control, 1 port C latch / pin view, 2 capture latch, 3 direction, 4 port B. The control register bits are: bit 7 event flag (read-only), bit 6 interrupt enable, bit 5 three-state variant, bit 4 handshake enable, bit 3 output direction, bit 2 pulse select, bit 1 edge select (1 rising, 0 falling), bit 0 strobe invert.
- R3: In simple mode (handshake enable 0), each port B write updates `pb_o` and makes the outgoing strobe active for PULSE_LEN (default 2) clock cycles, starting in the cycle after the write. The invert bit makes the active level low. A port B write in a handshake mode produces no pulse.
- R4: In simple mode and in full input handshake, the selected strobe edge copies `pc_i` into the capture latch. The other edge leaves the latch unchanged.
- R5: The selected incoming strobe edge sets the event flag, in every mode. `irq_o` is high exactly when the flag and the interrupt enable are both set.
- R6: In the input modes, the flag clears after a control read that sees the flag set, followed by a capture-latch read. A capture-latch read without that earlier control read leaves the flag set.
- R7: In output handshake mode, the flag clears after the control read followed by a capture-latch write. A capture-latch read does not clear it.
- R8: In full input handshake with level signalling, the strobe is active (ready) while no captured data is unread. It goes inactive in the cycle after the capturing edge, and returns after the capture latch is read.
- R9: In full output handshake with level signalling, a capture-latch write also loads the port C output latch and makes the strobe active from the next cycle. The selected incoming edge makes the strobe inactive.
- R10: With pulse select set in a full handshake mode, the strobe is a PULSE_LEN-cycle pulse. It is launched by a capture-latch read in input handshake and by a capture-latch write in output handshake.
- R11: A direction bit of 1 drives that pad from the port C latch. A direction bit of 0 leaves the pad undriven. A port C read returns the latch bit for output pins and the pad input for input pins.
- R12: In the three-state output variant, pads with direction 0 drive the capture latch contents while the incoming strobe is at its active level (high when edge select is 1, low when it is 0). Otherwise they follow the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| stra_i | input | 1 | Incoming strobe / acknowledge |
| strb_o | output | 1 | Outgoing strobe / ready |
| pc_i | input | 8 | Port C pad inputs |
| pc_o | output | 8 | Port C pad output values |
| pc_oe | output | 8 | Port C pad output enables |
| pb_o | output | 8 | Port B outputs |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `stra_i` is already synchronous to `clk` when SYNC_STAGES is 0. They also assume that `wr_en` and `rd_en` are single-cycle strobes that never coincide. The bench changes every input only on the falling clock edge. It issues each bus access as a one-cycle strobe and holds the incoming strobe low through reset. This keeps every edge the block sees a clean, deliberate one.

// File: rtl/phs_pkg.sv
package phs_pkg;

   localparam int CTRL_BITS = 7;

   localparam logic [2:0] ADR_CTRL  = 3'd0;
   localparam logic [2:0] ADR_PORTC = 3'd1;
   localparam logic [2:0] ADR_CAPT  = 3'd2;
   localparam logic [2:0] ADR_DIR   = 3'd3;
   localparam logic [2:0] ADR_PORTB = 3'd4;

   typedef struct packed {
      logic ien;
      logic tri_sel;
      logic hs_en;
      logic out_sel;
      logic pulse_sel;
      logic edge_sel;
      logic inv;
   } phs_ctrl_t;

   typedef enum logic [1:0] {
      MODE_SIMPLE  = 2'd0,
      MODE_HS_IN   = 2'd1,
      MODE_HS_OUT  = 2'd2,
      MODE_HS_TRI  = 2'd3
   } phs_mode_e;

   function automatic phs_mode_e phs_decode(phs_ctrl_t c);
      phs_mode_e m;
      if (!c.hs_en)         m = MODE_SIMPLE;
      else if (!c.out_sel)  m = MODE_HS_IN;
      else if (!c.tri_sel)  m = MODE_HS_OUT;
      else                  m = MODE_HS_TRI;
      return m;
   endfunction

endpackage

// File: rtl/phs_edge.sv
module phs_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stra_i,
   input  logic edge_sel,
   output logic edge_o,
   output logic active_o
);

   logic stra_s;
   logic stra_d;
   logic primed_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign stra_s = stra_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], stra_i};
         end
         assign stra_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stra_d   <= 1'b0;
         primed_q <= 1'b0;
      end else begin
         stra_d   <= stra_s;
         primed_q <= 1'b1;
      end
   end

   assign edge_o   = primed_q & (edge_sel ? (stra_s & ~stra_d) : (~stra_s & stra_d));
   assign active_o = edge_sel ? stra_s : ~stra_s;

   // R4
   edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);

endmodule

// File: rtl/phs_strobe.sv
module phs_strobe
   import phs_pkg::*;
#(
   parameter int PULSE_LEN = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  phs_mode_e mode,
   input  logic      pulse_sel,
   input  logic      inv,
   input  logic      pb_wr,
   input  logic      alt_rd,
   input  logic      alt_wr,
   input  logic      edge_i,
   output logic      strb_o
);

   localparam int CNT_W = $clog2(PULSE_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             in_hs;
   logic             out_hs;
   logic             fire;
   logic             stb_act;

   assign in_hs  = (mode == MODE_HS_IN);
   assign out_hs = (mode == MODE_HS_OUT) || (mode == MODE_HS_TRI);

   always_comb begin
      if (mode == MODE_SIMPLE) fire = pb_wr;
      else if (in_hs)          fire = pulse_sel & alt_rd;
      else                     fire = pulse_sel & alt_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (fire)           cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (in_hs) begin
         if (edge_i)       pend_q <= 1'b1;
         else if (alt_rd)  pend_q <= 1'b0;
      end else if (out_hs) begin
         if (alt_wr)       pend_q <= 1'b1;
         else if (edge_i)  pend_q <= 1'b0;
      end
   end

   always_comb begin
      if (mode == MODE_SIMPLE || pulse_sel) stb_act = (cnt_q != '0);
      else if (in_hs)                       stb_act = ~pend_q;
      else                                  stb_act = pend_q;
   end

   assign strb_o = stb_act ^ inv;

   // R3
   simple_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SIMPLE && pb_wr) |=> stb_act);

   // R8
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_hs && !pulse_sel && edge_i) |=> (!stb_act || mode != MODE_HS_IN || pulse_sel));

   // R9
   data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_hs && !pulse_sel && alt_wr) |=> (stb_act || !out_hs || pulse_sel));

   // R10
   pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LOAD);

endmodule

// File: rtl/phs_pads.sv
module phs_pads #(
   parameter int PORT_W = 8
) (
   input  logic [PORT_W-1:0] dir,
   input  logic [PORT_W-1:0] out_lat,
   input  logic [PORT_W-1:0] capt,
   input  logic              drive_all,
   input  logic [PORT_W-1:0] pad_i,
   output logic [PORT_W-1:0] pad_o,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] view
);

   generate
      for (genvar i = 0; i < PORT_W; i++) begin : g_bit
         assign pad_o[i]  = dir[i] ? out_lat[i] : capt[i];
         assign pad_oe[i] = dir[i] | drive_all;
         assign view[i]   = dir[i] ? out_lat[i] : pad_i[i];
      end
   endgenerate

endmodule

// File: rtl/strobe_port_ctrl.sv
module strobe_port_ctrl
   import phs_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int PULSE_LEN   = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [PORT_W-1:0] wdata,
   output logic [PORT_W-1:0] rdata,
   input  logic              stra_i,
   output logic              strb_o,
   input  logic [PORT_W-1:0] pc_i,
   output logic [PORT_W-1:0] pc_o,
   output logic [PORT_W-1:0] pc_oe,
   output logic [PORT_W-1:0] pb_o,
   output logic              irq_o
);

   generate
      if (PORT_W < 8) begin : g_bad_width
         $error("strobe_port_ctrl: PORT_W must be at least 8");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("strobe_port_ctrl: PULSE_LEN must be at least 1");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("strobe_port_ctrl: SYNC_STAGES must be 0 or 2..4");
      end
   endgenerate

   phs_ctrl_t         ctrl_q;
   phs_mode_e         mode;
   logic [PORT_W-1:0] dir_q;
   logic [PORT_W-1:0] lat_q;
   logic [PORT_W-1:0] capt_q;
   logic [PORT_W-1:0] pb_q;
   logic [PORT_W-1:0] view;
   logic              flag_q;
   logic              armed_q;
   logic              stra_edge;
   logic              stra_active;
   logic              out_mode;
   logic              ctrl_rd;
   logic              capt_rd;
   logic              capt_wr;
   logic              pb_wr;
   logic              clr_hit;

   assign mode     = phs_decode(ctrl_q);
   assign out_mode = (mode == MODE_HS_OUT) || (mode == MODE_HS_TRI);
   assign ctrl_rd  = rd_en && addr == ADR_CTRL;
   assign capt_rd  = rd_en && addr == ADR_CAPT;
   assign capt_wr  = wr_en && addr == ADR_CAPT;
   assign pb_wr    = wr_en && addr == ADR_PORTB;
   assign clr_hit  = armed_q && (out_mode ? capt_wr : capt_rd);

   phs_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .stra_i   (stra_i),
      .edge_sel (ctrl_q.edge_sel),
      .edge_o   (stra_edge),
      .active_o (stra_active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         dir_q  <= '0;
         lat_q  <= '0;
         pb_q   <= '0;
      end else if (wr_en) begin
         case (addr)
            ADR_CTRL:  ctrl_q <= phs_ctrl_t'(wdata[CTRL_BITS-1:0]);
            ADR_PORTC: lat_q  <= wdata;
            ADR_CAPT:  if (out_mode) lat_q <= wdata;
            ADR_DIR:   dir_q  <= wdata;
            ADR_PORTB: pb_q   <= wdata;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     capt_q <= '0;
      else if (out_mode && capt_wr)   capt_q <= wdata;
      else if (!out_mode && stra_edge) capt_q <= pc_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (stra_edge)     flag_q <= 1'b1;
         else if (clr_hit)  flag_q <= 1'b0;
         if (clr_hit)                armed_q <= 1'b0;
         else if (ctrl_rd && flag_q) armed_q <= 1'b1;
      end
   end

   phs_strobe #(.PULSE_LEN(PULSE_LEN)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .pulse_sel (ctrl_q.pulse_sel),
      .inv       (ctrl_q.inv),
      .pb_wr     (pb_wr),
      .alt_rd    (capt_rd),
      .alt_wr    (capt_wr),
      .edge_i    (stra_edge),
      .strb_o    (strb_o)
   );

   phs_pads #(.PORT_W(PORT_W)) u_pads (
      .dir       (dir_q),
      .out_lat   (lat_q),
      .capt      (capt_q),
      .drive_all ((mode == MODE_HS_TRI) && stra_active),
      .pad_i     (pc_i),
      .pad_o     (pc_o),
      .pad_oe    (pc_oe),
      .view      (view)
   );

   always_comb begin
      rdata = '0;
      case (addr)
         ADR_CTRL:  rdata[7:0] = {flag_q, ctrl_q};
         ADR_PORTC: rdata = view;
         ADR_CAPT:  rdata = capt_q;
         ADR_DIR:   rdata = dir_q;
         ADR_PORTB: rdata = pb_q;
         default:   rdata = '0;
      endcase
   end

   assign pb_o  = pb_q;
   assign irq_o = flag_q & ctrl_q.ien;

   // R5
   flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stra_edge |=> flag_q);

   // R6
   flag_clear_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(clr_hit));

   // R7
   out_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mode && capt_rd && !wr_en && flag_q) |=> flag_q);

   // R4
   capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stra_edge && !capt_wr) |=> $stable(capt_q));

endmodule

// File: tb/strobe_port_ctrl_bench.sv
module strobe_port_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       stra_i = 1'b0;
   logic       strb_o;
   logic [7:0] pc_i = '0;
   logic [7:0] pc_o;
   logic [7:0] pc_oe;
   logic [7:0] pb_o;
   logic       irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   strobe_port_ctrl u_strobe_port_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .stra_i(stra_i), .strb_o(strb_o),
      .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe), .pb_o(pb_o), .irq_o(irq_o)
   );

   localparam logic [2:0] A_CTRL = 3'd0, A_PC = 3'd1, A_CAP = 3'd2, A_DIR = 3'd3, A_PB = 3'd4;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic set_stra(input logic v);
      stra_i = v;
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk("R1 pc_oe", pc_oe, 8'h00);
      chk("R1 strb", strb_o, 1'b0);
      chk("R1 irq", irq_o, 1'b0);
      bus_rd(A_CTRL, d); chk("R1 ctrl", d, 8'h00);
      bus_rd(A_DIR, d);  chk("R1 dir", d, 8'h00);
   endtask

   task automatic t_simple_out;
      bus_wr(A_PB, 8'hA5);
      chk("R3 pb_o", pb_o, 8'hA5);
      chk("R3 pulse c1", strb_o, 1'b1);
      @(negedge clk); chk("R3 pulse c2", strb_o, 1'b1);
      @(negedge clk); chk("R3 pulse end", strb_o, 1'b0);
      bus_wr(A_CTRL, 8'h01);
      chk("R3 inv idle", strb_o, 1'b1);
      bus_wr(A_PB, 8'h5A);
      chk("R3 inv c1", strb_o, 1'b0);
      @(negedge clk); chk("R3 inv c2", strb_o, 1'b0);
      @(negedge clk); chk("R3 inv end", strb_o, 1'b1);
      bus_wr(A_CTRL, 8'h18);
      bus_wr(A_PB, 8'h3C);
      chk("R3 no pulse in hs", strb_o, 1'b0);
      @(negedge clk); chk("R3 no pulse in hs c2", strb_o, 1'b0);
   endtask

   task automatic t_simple_in;
      logic [7:0] d;
      bus_wr(A_CTRL, 8'h42);
      pc_i = 8'h3C;
      set_stra(1'b1);
      chk("R5 irq on rise", irq_o, 1'b1);
      bus_rd(A_CAP, d); chk("R4 capture", d, 8'h3C);
      chk("R6 unarmed read keeps flag", irq_o, 1'b1);
      pc_i = 8'h11;
      set_stra(1'b0);
      bus_rd(A_CAP, d); chk("R4 other edge ignored", d, 8'h3C);
      bus_rd(A_CTRL, d); chk("R2 ctrl with flag", d, 8'hC2);
      bus_rd(A_CAP, d);
      chk("R6 clear sequence", irq_o, 1'b0);
      bus_wr(A_CTRL, 8'h40);
      set_stra(1'b1);
      chk("R5 rise ignored when falling", irq_o, 1'b0);
      set_stra(1'b0);
      chk("R5 irq on fall", irq_o, 1'b1);
      bus_rd(A_CAP, d); chk("R4 falling capture", d, 8'h11);
      bus_rd(A_CTRL, d);
      bus_rd(A_CAP, d);
      chk("R6 clear after fall", irq_o, 1'b0);
   endtask

   task automatic t_full_in;
      logic [7:0] d;
      bus_wr(A_CTRL, 8'h52);
      chk("R8 ready idle", strb_o, 1'b1);
      pc_i = 8'h5A;
      set_stra(1'b1);
      chk("R8 not ready after latch", strb_o, 1'b0);
      chk("R5 flag in full input", irq_o, 1'b1);
      set_stra(1'b0);
      bus_rd(A_CTRL, d);
      bus_rd(A_CAP, d); chk("R4 full input capture", d, 8'h5A);
      chk("R8 ready after read", strb_o, 1'b1);
      chk("R6 clear full input", irq_o, 1'b0);
   endtask

   task automatic t_full_out;
      logic [7:0] d;
      bus_wr(A_DIR, 8'hFF);
      bus_wr(A_CTRL, 8'h5A);
      chk("R9 idle", strb_o, 1'b0);
      bus_wr(A_CAP, 8'h77);
      chk("R9 data ready", strb_o, 1'b1);
      chk("R9 latch loads port", pc_o, 8'h77);
      chk("R11 all outputs", pc_oe, 8'hFF);
      set_stra(1'b1);
      chk("R9 ack drops strobe", strb_o, 1'b0);
      chk("R5 flag on ack", irq_o, 1'b1);
      set_stra(1'b0);
      bus_rd(A_CTRL, d);
      bus_rd(A_CAP, d);
      chk("R7 read does not clear", irq_o, 1'b1);
      bus_wr(A_CAP, 8'h12);
      chk("R7 write clears", irq_o, 1'b0);
      chk("R9 ready again", strb_o, 1'b1);
      set_stra(1'b1);
      set_stra(1'b0);
   endtask

   task automatic t_pulse;
      logic [7:0] d;
      bus_wr(A_CTRL, 8'h14);
      chk("R10 in idle", strb_o, 1'b0);
      bus_rd(A_CAP, d);
      chk("R10 in c1", strb_o, 1'b1);
      @(negedge clk); chk("R10 in c2", strb_o, 1'b1);
      @(negedge clk); chk("R10 in end", strb_o, 1'b0);
      bus_wr(A_CTRL, 8'h1C);
      bus_wr(A_CAP, 8'h99);
      chk("R10 out c1", strb_o, 1'b1);
      @(negedge clk); chk("R10 out c2", strb_o, 1'b1);
      @(negedge clk); chk("R10 out end", strb_o, 1'b0);
   endtask

   task automatic t_dir;
      logic [7:0] d;
      bus_wr(A_CTRL, 8'h00);
      bus_wr(A_DIR, 8'h0F);
      bus_wr(A_PC, 8'hA6);
      pc_i = 8'h50;
      #1;
      chk("R11 oe", pc_oe, 8'h0F);
      chk("R11 drive", pc_o & 8'h0F, 8'h06);
      @(negedge clk);
      bus_rd(A_PC, d); chk("R11 pin view", d, 8'h56);
      bus_rd(A_DIR, d); chk("R2 dir readback", d, 8'h0F);
   endtask

   task automatic t_tri;
      bus_wr(A_CTRL, 8'h3A);
      bus_wr(A_DIR, 8'hF0);
      bus_wr(A_CAP, 8'h3C);
      chk("R12 inactive follows dir", pc_oe, 8'hF0);
      stra_i = 1'b1;
      #1;
      chk("R12 active drives all", pc_oe, 8'hFF);
      chk("R12 latch on pads", pc_o, 8'h3C);
      @(negedge clk);
      stra_i = 1'b0;
      #1;
      chk("R12 released", pc_oe, 8'hF0);
      @(negedge clk);
      bus_wr(A_CTRL, 8'h38);
      chk("R12 active low drives all", pc_oe, 8'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_simple_out();
      t_simple_in();
      t_full_in();
      t_full_out();
      t_pulse();
      t_dir();
      t_tri();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule